// File: doc/BRIEF.md
# Command-Driven Dual-Mode SPI Engine

This block is a serial peripheral engine that runs either as the bus master or as a bus slave. Words to send are pushed into a transmit FIFO. Each entry holds a 16-bit data word and a 7-bit command. Every frame that arrives is written as one entry into a receive FIFO, which software or a DMA engine drains. In master mode the engine takes the next transmit entry, reads the frame length and the chip-select line from that entry's command, and then drives SCK and the chosen select itself. In slave mode the command is ignored. The engine follows an external SCK and select, takes its frame length from a static input, and loads the next transmit word when the select is asserted.

The two shift registers exchange data over the serial lines. Data leaves MSB first on the falling SCK edge and is captured on the rising edge, so after a frame each side holds the word the other side sent. A sticky completion flag marks each finished frame. A sticky overflow flag records a frame that was dropped because the receive FIFO was full. A disable input freezes the serial logic in place and leaves the FIFO contents as they are.

Top module: `spi_cmd_engine`

## Requirements
- R1: The frame length N in master mode is the command's bits [3:0] plus one. Any value of bits [3:0] below 3 gives N = 4, so N ranges from 4 to 16.
- R2: In master mode, while enabled and idle, the engine starts a frame whenever the transmit FIFO holds an entry, and removes that entry.
- R3: Only the low N bits of the data word are sent, MSB first, on `sdo`. `sdo` changes after the falling SCK edge, and `sdi` is sampled on the rising edge.
- R4: Each completed frame puts the N received bits, right-aligned and zero-extended, as one entry into the receive FIFO.
- R5: During a master frame only `cs_n_o[i]` is low, where i is command bits [6:4]. All selects are high when idle and in slave mode.
- R6: SCK idles low, and its half-period h is `clk_div`/2 system clocks (at least 1). The select goes low h cycles before the first rising edge and returns high h cycles after the last falling edge, so it stays low for h*(2N+1) cycles.
- R7: In slave mode the engine follows `sck_i`/`ss_n_i`, uses N = `slv_size_m1`+1 with the same clamp, and ignores the entry's command. It loads the transmit word when the select falls, or sends zeros if the FIFO is empty.
- R8: `done_flag` is set at the end of every completed frame and stays set until `done_clr` is pulsed.
- R9: A frame that completes while the receive FIFO is full is dropped and sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed.
- R10: While `disable_i` is high, no frame starts, SCK and the selects hold their values, and both FIFOs keep their contents.
- R11: Both FIFOs are 4 entries deep and export full and empty. A push into a full FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 = master, 0 = slave; change only while idle |
| disable_i | input | 1 | Freezes the serial logic |
| clk_div | input | 8 | Even SCK divider in master mode |
| slv_size_m1 | input | 4 | Frame length minus one in slave mode |
| tx_push | input | 1 | Write strobe for the transmit FIFO |
| tx_data | input | 16 | Data word to send |
| tx_cmd | input | 7 | [3:0] length minus one, [6:4] chip-select index |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Removes the head of the receive FIFO |
| rx_data | output | 16 | Head of the receive FIFO |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| done_flag | output | 1 | Sticky frame-complete flag |
| done_clr | input | 1 | Clears `done_flag` (write-one-to-clear) |
| ovf_flag | output | 1 | Sticky receive-overflow flag |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| sck_o | output | 1 | SCK in master mode |
| cs_n_o | output | 8 | Active-low chip selects |
| sck_i | input | 1 | External SCK in slave mode |
| ss_n_i | input | 1 | External select in slave mode, active low |
| sdi | input | 1 | Serial data in (MISO in master mode, MOSI in slave mode) |
| sdo | output | 1 | Serial data out (MOSI in master mode, MISO in slave mode) |

## Verification
Master frames are driven with random data, random length codes (including the clamped codes 0 to 2), random select indices and random dividers. A bench slave model returns its own word. The model's received word shows whether bit order and masking are correct. The FIFO entry shows whether sampling and zero-extension are correct. The count of select-low cycles shows whether the lead and trail half-periods are right. Five entries pushed while the engine is disabled separate the frozen engine from the ignored push into a full FIFO. A fifth frame with the receive FIFO full exercises the drop. Slave frames are run with a command that conflicts with the slave length, with an empty transmit FIFO, and with a length code below the clamp.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;
   typedef enum logic [1:0] {M_IDLE, M_LEAD, M_SHIFT, M_TRAIL} mst_e;
   typedef enum logic [1:0] {S_IDLE, S_ACT, S_FIN} slv_e;
   localparam int MIN_FRAME = 4;
endpackage

// File: rtl/spi_fifo.sv
`timescale 1ns/1ps
module spi_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          wr, rd;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign wr    = push & ~full;
   assign rd    = pop & ~empty;
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (wr) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
         if (rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
         case ({wr, rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/spi_master_seq.sv
`timescale 1ns/1ps
module spi_master_seq
   import spi_eng_pkg::*;
#(
   parameter int DW    = 16,
   parameter int LEN_W = 4,
   parameter int CS_W  = 3,
   parameter int DIV_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  hold,
   input  logic                  tx_avail,
   input  logic [DW-1:0]         tx_word,
   input  logic [LEN_W+CS_W-1:0] tx_cmd,
   input  logic [DIV_W-1:0]      clk_div,
   input  logic                  sdi,
   output logic                  tx_take,
   output logic                  sck,
   output logic                  sdo,
   output logic                  cs_act,
   output logic [CS_W-1:0]       cs_idx,
   output logic                  done,
   output logic [DW-1:0]         rx_word
);
   localparam int LN_W = LEN_W + 1;

   mst_e             st;
   logic [DIV_W-1:0] tmr, half_r, half_c;
   logic [LN_W-1:0]  len_r, bits, req_len;
   logic [DW-1:0]    txsh, rxsh;
   logic             tick;

   always_comb begin
      if (tx_cmd[LEN_W-1:0] < LEN_W'(MIN_FRAME - 1))
         req_len = LN_W'(MIN_FRAME);
      else
         req_len = {1'b0, tx_cmd[LEN_W-1:0]} + LN_W'(1);
      half_c = (clk_div[DIV_W-1:1] == '0) ? DIV_W'(1) : DIV_W'(clk_div[DIV_W-1:1]);
   end

   assign tx_take = (st == M_IDLE) && run && tx_avail;
   assign tick    = (tmr == '0) && !hold;
   assign cs_act  = (st != M_IDLE);
   assign sdo     = txsh[DW-1];
   assign rx_word = rxsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= M_IDLE;
         tmr    <= '0;
         half_r <= DIV_W'(1);
         len_r  <= LN_W'(MIN_FRAME);
         bits   <= '0;
         txsh   <= '0;
         rxsh   <= '0;
         sck    <= 1'b0;
         cs_idx <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!hold && st != M_IDLE && tmr != '0) tmr <= tmr - 1'b1;
         case (st)
            M_IDLE: begin
               if (tx_take) begin
                  st     <= M_LEAD;
                  tmr    <= half_c - 1'b1;
                  half_r <= half_c;
                  len_r  <= req_len;
                  bits   <= '0;
                  txsh   <= tx_word << (DW - int'(req_len));
                  rxsh   <= '0;
                  cs_idx <= tx_cmd[LEN_W+CS_W-1:LEN_W];
               end
            end
            M_LEAD: begin
               if (tick) begin
                  sck  <= 1'b1;
                  rxsh <= {rxsh[DW-2:0], sdi};
                  bits <= bits + 1'b1;
                  tmr  <= half_r - 1'b1;
                  st   <= M_SHIFT;
               end
            end
            M_SHIFT: begin
               if (tick) begin
                  tmr <= half_r - 1'b1;
                  if (sck) begin
                     sck <= 1'b0;
                     if (bits == len_r) st <= M_TRAIL;
                     else               txsh <= txsh << 1;
                  end else begin
                     sck  <= 1'b1;
                     rxsh <= {rxsh[DW-2:0], sdi};
                     bits <= bits + 1'b1;
                  end
               end
            end
            M_TRAIL: begin
               if (tick) begin
                  st   <= M_IDLE;
                  done <= 1'b1;
               end
            end
            default: st <= M_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_slave_seq.sv
`timescale 1ns/1ps
module spi_slave_seq
   import spi_eng_pkg::*;
#(
   parameter int DW    = 16,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic             tx_avail,
   input  logic [DW-1:0]    tx_word,
   input  logic [LEN_W-1:0] len_cfg,
   input  logic             sck_i,
   input  logic             ss_n_i,
   input  logic             sdi,
   output logic             tx_take,
   output logic             sdo,
   output logic             done,
   output logic [DW-1:0]    rx_word
);
   localparam int LN_W = LEN_W + 1;

   slv_e            st;
   logic [2:0]      sck_s, ss_s;
   logic [1:0]      sdi_s;
   logic            rise, fall, ss_fall, ss_rise;
   logic [LN_W-1:0] len_c, len_r, bits;
   logic [DW-1:0]   txsh, rxsh;

   always_comb begin
      if (len_cfg < LEN_W'(MIN_FRAME - 1)) len_c = LN_W'(MIN_FRAME);
      else                                 len_c = {1'b0, len_cfg} + LN_W'(1);
   end

   assign rise    = sck_s[1] & ~sck_s[2];
   assign fall    = ~sck_s[1] & sck_s[2];
   assign ss_fall = ~ss_s[1] & ss_s[2];
   assign ss_rise = ss_s[1] & ~ss_s[2];
   assign tx_take = (st == S_IDLE) && run && ss_fall && tx_avail;
   assign sdo     = (st == S_ACT) ? txsh[DW-1] : 1'b0;
   assign rx_word = rxsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_s <= '0;
         ss_s  <= '1;
         sdi_s <= '0;
      end else begin
         sck_s <= {sck_s[1:0], sck_i};
         ss_s  <= {ss_s[1:0], ss_n_i};
         sdi_s <= {sdi_s[0], sdi};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         len_r <= LN_W'(MIN_FRAME);
         bits  <= '0;
         txsh  <= '0;
         rxsh  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!hold) begin
            case (st)
               S_IDLE: begin
                  if (run && ss_fall) begin
                     st    <= S_ACT;
                     len_r <= len_c;
                     bits  <= '0;
                     rxsh  <= '0;
                     txsh  <= tx_avail ? (tx_word << (DW - int'(len_c))) : '0;
                  end
               end
               S_ACT: begin
                  if (ss_rise) begin
                     st <= S_IDLE;
                  end else if (rise) begin
                     rxsh <= {rxsh[DW-2:0], sdi_s[1]};
                     bits <= bits + 1'b1;
                     if (bits + 1'b1 == len_r) begin
                        done <= 1'b1;
                        st   <= S_FIN;
                     end
                  end else if (fall) begin
                     txsh <= txsh << 1;
                  end
               end
               S_FIN: begin
                  if (ss_rise) st <= S_IDLE;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine #(
   parameter int DW    = 16,
   parameter int NCS   = 8,
   parameter int DEPTH = 4,
   parameter int DIV_W = 8,
   localparam int LEN_W = $clog2(DW),
   localparam int CS_W  = $clog2(NCS),
   localparam int CMD_W = LEN_W + CS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_master,
   input  logic             disable_i,
   input  logic [DIV_W-1:0] clk_div,
   input  logic [LEN_W-1:0] slv_size_m1,
   input  logic             tx_push,
   input  logic [DW-1:0]    tx_data,
   input  logic [CMD_W-1:0] tx_cmd,
   output logic             tx_full,
   output logic             tx_empty,
   input  logic             rx_pop,
   output logic [DW-1:0]    rx_data,
   output logic             rx_full,
   output logic             rx_empty,
   output logic             done_flag,
   input  logic             done_clr,
   output logic             ovf_flag,
   input  logic             ovf_clr,
   output logic             sck_o,
   output logic [NCS-1:0]   cs_n_o,
   input  logic             sck_i,
   input  logic             ss_n_i,
   input  logic             sdi,
   output logic             sdo
);
   if (DW < 4) begin : g_bad_dw
      initial $fatal(1, "spi_cmd_engine: DW must be at least 4");
   end
   if (NCS < 2 || DEPTH < 2 || DIV_W < 2) begin : g_bad_cfg
      initial $fatal(1, "spi_cmd_engine: NCS, DEPTH and DIV_W must be at least 2");
   end

   logic [CMD_W+DW-1:0] tx_head;
   logic                tx_pop, m_take, s_take;
   logic                m_run, s_run;
   logic                m_sdo, s_sdo, m_done, s_done, m_cs_act;
   logic [CS_W-1:0]     m_cs_idx;
   logic [DW-1:0]       m_rx, s_rx, rx_word;
   logic                frame_done, rx_push;

   assign m_run  = mode_master & ~disable_i;
   assign s_run  = ~mode_master & ~disable_i;
   assign tx_pop = m_take | s_take;

   spi_fifo #(.W(CMD_W + DW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .din({tx_cmd, tx_data}),
      .pop(tx_pop), .dout(tx_head),
      .full(tx_full), .empty(tx_empty)
   );

   spi_master_seq #(.DW(DW), .LEN_W(LEN_W), .CS_W(CS_W), .DIV_W(DIV_W)) u_mst (
      .clk(clk), .rst_n(rst_n), .run(m_run), .hold(disable_i),
      .tx_avail(~tx_empty), .tx_word(tx_head[DW-1:0]),
      .tx_cmd(tx_head[CMD_W+DW-1:DW]), .clk_div(clk_div), .sdi(sdi),
      .tx_take(m_take), .sck(sck_o), .sdo(m_sdo), .cs_act(m_cs_act),
      .cs_idx(m_cs_idx), .done(m_done), .rx_word(m_rx)
   );

   spi_slave_seq #(.DW(DW), .LEN_W(LEN_W)) u_slv (
      .clk(clk), .rst_n(rst_n), .run(s_run), .hold(disable_i),
      .tx_avail(~tx_empty), .tx_word(tx_head[DW-1:0]),
      .len_cfg(slv_size_m1), .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi(sdi),
      .tx_take(s_take), .sdo(s_sdo), .done(s_done), .rx_word(s_rx)
   );

   assign sdo        = mode_master ? m_sdo : s_sdo;
   assign frame_done = m_done | s_done;
   assign rx_word    = m_done ? m_rx : s_rx;
   assign rx_push    = frame_done & ~rx_full;

   for (genvar i = 0; i < NCS; i++) begin : g_cs
      assign cs_n_o[i] = ~(m_cs_act && (m_cs_idx == CS_W'(i)));
   end

   spi_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .din(rx_word),
      .pop(rx_pop), .dout(rx_data),
      .full(rx_full), .empty(rx_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_flag <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         if (frame_done)    done_flag <= 1'b1;
         else if (done_clr) done_flag <= 1'b0;
         if (frame_done && rx_full) ovf_flag <= 1'b1;
         else if (ovf_clr)          ovf_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi_cmd_engine_chk #(
   parameter int NCS = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           mode_master,
   input logic           disable_i,
   input logic           done_clr,
   input logic           done_flag,
   input logic           ovf_flag,
   input logic           ovf_clr,
   input logic           rx_full,
   input logic           tx_full,
   input logic           tx_empty,
   input logic           sck_o,
   input logic [NCS-1:0] cs_n_o
);
   AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n_o) <= 1); // R5
   AST_SLAVE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_master && !$past(mode_master)) |-> (&cs_n_o)); // R5
   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n_o) |-> !sck_o); // R6
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !done_clr) |=> done_flag); // R8
   AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(rx_full)); // R9
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag); // R9
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (disable_i && $past(disable_i)) |-> ($stable(sck_o) && $stable(cs_n_o))); // R10
   AST_FIFO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty)); // R11
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NCS(NCS)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .disable_i(disable_i),
   .done_clr(done_clr), .done_flag(done_flag), .ovf_flag(ovf_flag),
   .ovf_clr(ovf_clr), .rx_full(rx_full), .tx_full(tx_full),
   .tx_empty(tx_empty), .sck_o(sck_o), .cs_n_o(cs_n_o)
);

// File: tb/spi_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_cmd_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_master = 1'b1, disable_i = 1'b0;
   logic [7:0]  clk_div = 8'd4;
   logic [3:0]  slv_size_m1 = 4'd7;
   logic        tx_push = 1'b0, rx_pop = 1'b0, done_clr = 1'b0, ovf_clr = 1'b0;
   logic [15:0] tx_data = '0;
   logic [6:0]  tx_cmd = '0;
   logic        tx_full, tx_empty, rx_full, rx_empty, done_flag, ovf_flag;
   logic [15:0] rx_data;
   logic        sck_o, sdo, sdi;
   logic [7:0]  cs_n_o;
   logic        sck_drv = 1'b0, ss_drv = 1'b1, sdi_drv = 1'b0;

   int total = 0, bad = 0;
   bit finished = 0;

   // bench-side slave model for master mode
   logic [15:0] m_tx = '0, m_sh = '0, m_rx = '0;
   int          m_len = 8, m_cnt = 0;
   logic [7:0]  m_seen = '0;
   logic        m_prev_cs = 1'b0, m_prev_sck = 1'b0, m_multi = 1'b0;
   logic        cs_any;

   assign cs_any = ~&cs_n_o;
   assign sdi    = mode_master ? m_sh[15] : sdi_drv;

   always #5 clk = ~clk;

   spi_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .disable_i(disable_i),
      .clk_div(clk_div), .slv_size_m1(slv_size_m1), .tx_push(tx_push),
      .tx_data(tx_data), .tx_cmd(tx_cmd), .tx_full(tx_full), .tx_empty(tx_empty),
      .rx_pop(rx_pop), .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty),
      .done_flag(done_flag), .done_clr(done_clr), .ovf_flag(ovf_flag),
      .ovf_clr(ovf_clr), .sck_o(sck_o), .cs_n_o(cs_n_o), .sck_i(sck_drv),
      .ss_n_i(ss_drv), .sdi(sdi), .sdo(sdo)
   );

   always @(negedge clk) begin
      if (cs_any && !m_prev_cs) begin
         m_sh   <= m_tx << (16 - m_len);
         m_rx   <= '0;
         m_cnt  <= 1;
         m_seen <= ~cs_n_o;
         m_multi <= ($countones(~cs_n_o) > 1);
      end else if (cs_any) begin
         m_cnt  <= m_cnt + 1;
         m_seen <= m_seen | ~cs_n_o;
         if ($countones(~cs_n_o) > 1) m_multi <= 1'b1;
         if (sck_o && !m_prev_sck) m_rx <= {m_rx[14:0], sdo};
         if (!sck_o && m_prev_sck) m_sh <= m_sh << 1;
      end
      m_prev_cs  <= cs_any;
      m_prev_sck <= sck_o;
   end

   function automatic int exp_len(input logic [3:0] s);
      return (s < 4'd3) ? 4 : int'(s) + 1;
   endfunction
   function automatic logic [15:0] lowbits(input logic [15:0] v, input int n);
      return v & 16'((32'd1 << n) - 1);
   endfunction
   function automatic int half_of(input logic [7:0] d);
      return (d / 2 == 0) ? 1 : int'(d / 2);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [15:0] d, input logic [3:0] sz, input logic [2:0] cs);
      @(negedge clk);
      tx_data = d; tx_cmd = {cs, sz}; tx_push = 1'b1;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic pulse_pop();
      rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
   endtask

   task automatic clear_done();
      done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done_flag && t < 20000) begin @(negedge clk); t++; end
      @(negedge clk);
   endtask

   task automatic run_master(input logic [15:0] d, input logic [3:0] sz,
                             input logic [2:0] cs, input logic [7:0] div,
                             input logic [15:0] md);
      int n = exp_len(sz);
      int h = half_of(div);
      clk_div = div; m_tx = md; m_len = n;
      push(d, sz, cs);
      wait_done();
      check("R8 done set", done_flag, 1);
      check("R4 rx word", rx_data, lowbits(md, n));
      check("R3 sent bits", m_rx, lowbits(d, n));
      check("R5 select", {m_multi, m_seen}, {1'b0, 8'(1 << cs)});
      check("R6 select window", m_cnt, h * (2 * n + 1));
      check("R1 R2 one entry", {rx_empty, tx_empty}, 2'b01);
      pulse_pop();
      clear_done();
      check("R8 done cleared", done_flag, 0);
   endtask

   task automatic slave_xfer(input logic [15:0] mw, input int n, output logic [15:0] cap,
                             output logic cs_bad);
      cap = '0; cs_bad = 1'b0;
      @(negedge clk); ss_drv = 1'b0;
      repeat (6) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         sdi_drv = mw[n-1-i];
         repeat (6) @(negedge clk);
         cap = {cap[14:0], sdo};
         if (!(&cs_n_o)) cs_bad = 1'b1;
         sck_drv = 1'b1;
         repeat (6) @(negedge clk);
         sck_drv = 1'b0;
      end
      repeat (6) @(negedge clk);
      ss_drv = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] cap;
      logic        csb;
      int unsigned seed;
      seed = $urandom(32'd2024);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R11 reset flags", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
      check("R5 reset selects", cs_n_o, 8'hFF);
      check("R6 reset sck", sck_o, 0);
      check("R8 R9 reset flags", {done_flag, ovf_flag}, 2'b00);

      // directed master frames: full length, clamp codes, divider of 1
      run_master(16'hA53C, 4'd15, 3'd7, 8'd4, 16'h3CA5);
      run_master(16'hFFF6, 4'd0, 3'd0, 8'd2, 16'h000B);   // R1 clamp to 4
      run_master(16'h1239, 4'd2, 3'd3, 8'd1, 16'hFFFF);   // R1 clamp, h=1
      run_master(16'h00AB, 4'd3, 3'd4, 8'd6, 16'h0005);   // R1 shortest coded length

      // random master frames
      for (int k = 0; k < 24; k++) begin
         run_master(16'($urandom), 4'($urandom), 3'($urandom),
                    8'(2 * ($urandom % 4) + 2), 16'($urandom));
      end

      // R10 R11: disabled engine, overfilled TX FIFO
      disable_i = 1'b1; clk_div = 8'd2; m_tx = 16'h00C3; m_len = 8;
      for (int k = 0; k < 5; k++) push(16'h1200 + 16'(k), 4'd7, 3'd2);
      check("R11 tx full", tx_full, 1);
      repeat (40) @(negedge clk);
      check("R10 no start selects", cs_n_o, 8'hFF);
      check("R10 no start sck", sck_o, 0);
      check("R10 tx kept", {tx_full, rx_empty}, 2'b11);
      disable_i = 1'b0;
      begin
         int t = 0;
         while (!(tx_empty && !cs_any) && t < 5000) begin @(negedge clk); t++; end
      end
      repeat (4) @(negedge clk);
      check("R11 four frames only", m_rx, 16'h0003);
      check("R9 rx full no ovf", {rx_full, ovf_flag}, 2'b10);
      clear_done();
      push(16'h1205, 4'd7, 3'd2);
      wait_done();
      check("R9 overflow set", ovf_flag, 1);
      check("R3 fifth frame sent", m_rx, 16'h0005);
      for (int k = 0; k < 4; k++) begin
         check("R4 kept entry", rx_data, 16'h00C3);
         pulse_pop();
      end
      check("R9 dropped frame", rx_empty, 1);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
      check("R9 ovf cleared", ovf_flag, 0);
      clear_done();

      // R7 slave mode
      mode_master = 1'b0; slv_size_m1 = 4'd11;
      push(16'h5A3C, 4'd3, 3'd5);
      slave_xfer(16'hBEEF, 12, cap, csb);
      check("R7 slave sent", cap, 16'h0A3C);
      check("R7 slave rx", rx_data, 16'h0EEF);
      check("R7 R5 no select", csb, 0);
      check("R8 slave done", done_flag, 1);
      pulse_pop(); clear_done();
      slave_xfer(16'h0F0F, 12, cap, csb);
      check("R7 empty sends zero", cap, 16'h0000);
      check("R7 slave rx2", rx_data, 16'h0F0F);
      pulse_pop(); clear_done();
      slv_size_m1 = 4'd1;
      push(16'hFFF9, 4'd15, 3'd1);
      slave_xfer(16'h0006, 4, cap, csb);
      check("R7 R1 slave clamp sent", cap, 16'h0009);
      check("R7 R1 slave clamp rx", rx_data, 16'h0006);
      check("R2 slave pop", {tx_empty, rx_empty}, 2'b10);
      pulse_pop();

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule